// File: doc/BRIEF.md
# Slow-Clock Time Snapshot Register

This block keeps a 48-bit time counter that advances once per rising edge of a slow clock. A host on a faster bus clock can read that counter without ever seeing a torn value. The host does not read the running counter. It writes a command bit to request a capture. The block carries the request into the slow domain and copies the counter into a holding register there. It then returns an acknowledge to the bus domain, where a ready flag is raised. The host polls the ready flag, reads the lower 32 bits and the upper 16 bits from two separate addresses, and joins them into one value. A separate clear command drops the ready flag before the next capture.

The request travels as a toggle through a two-flop synchronizer into the slow domain. The acknowledge returns as a toggle through a second two-flop synchronizer. A capture therefore completes within a few slow-clock periods. The holding register changes only at a capture edge, so it is stable whenever the ready flag is set. A request written while an earlier one is still in flight is folded into it rather than queued.

Top module: `rtc_snap_top`

## Requirements
- R1: After reset, the ready flag (bit 0 at address 0) and the busy flag (bit 1 at address 0) read 0, and both snapshot words read 0.
- R2: The counter starts at the value CNT_INIT and adds one on every rising slow-clock edge, wrapping modulo 2^48. Successive captures therefore increase by the number of slow edges between them, with the low word carrying into the high word.
- R3: A write to address 0 with the command bit set captures the counter. The captured value equals CNT_INIT plus some number n of slow edges counted since reset, where n is at least the count at the write and less than the count when the ready flag is first seen. Each request produces exactly one capture strobe.
- R4: The ready flag rises within 74 bus cycles of the request write when the slow clock period is 170 ns.
- R5: The ready flag stays set until a write to address 1 with the command bit set. A write to address 1 with the bit clear leaves the flag unchanged.
- R6: Address 2 returns counter bits 31:0. Address 3 returns counter bits 47:32 in its bits 15:0, with bits 31:16 reading 0.
- R7: The snapshot words hold their value between captures, even while the counter keeps running.
- R8: A request written while a capture is still pending merges with it and produces no second capture.
- R9: The busy flag is 1 from the cycle after an accepted request until the cycle in which the ready flag rises. It reads 0 once the ready flag is seen.
- R10: A write to address 0 with the command bit clear starts no capture and sets neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Fast bus clock |
| slowClk | input | 1 | Slow time-base clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| busWrEn | input | 1 | Write strobe, one bus cycle |
| busAddr | input | 2 | Register address: 0 command/status, 1 clear, 2 low word, 3 high word |
| busWrBit | input | 1 | Command bit carried by a write |
| busRdData | output | 32 | Read data for busAddr, combinational |

## Verification
The hardest case to reach from the ports is a second request that arrives while the first is still crossing the two clock domains. It must be absorbed without leaving a stray capture behind. The stimulus writes the request twice on adjacent bus cycles, waits for the ready flag and clears it. It then idles for many slow periods and confirms that neither flag comes back. A second hard case is carry and wrap at the top of the counter. The bench starts the counter 1500 slow edges below 2^48 and keeps issuing random captures until the count has passed through both the low-word carry and the full wrap.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  typedef enum logic [1:0] {
    ADDR_CMD = 2'd0,
    ADDR_CLR = 2'd1,
    ADDR_LO  = 2'd2,
    ADDR_HI  = 2'd3
  } regAddr_t;

  // Strobes from control to datapath, slow clock domain.
  typedef struct packed {
    logic capture;
  } slowStrobes_t;

endpackage

// File: rtl/rtc_snap_sync.sv
module rtc_snap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_snap_ctrl.sv
module rtc_snap_ctrl
  import rtc_snap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         busClk,
  input  logic         slowClk,
  input  logic         rstN,
  input  logic         busWrEn,
  input  logic [1:0]   busAddr,
  input  logic         busWrBit,
  output slowStrobes_t stb,
  output logic         validQ,
  output logic         pending
);
  logic updWr, clrWr;
  logic reqTgl, reqSync, reqSeen;
  logic ackSync, ackSeen, done;

  assign updWr = busWrEn && (busAddr == ADDR_CMD) && busWrBit;
  assign clrWr = busWrEn && (busAddr == ADDR_CLR) && busWrBit;

  // Bus side: request toggle, merged while a request is in flight.
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                  reqTgl <= 1'b0;
    else if (updWr && !pending) reqTgl <= ~reqTgl;
  end

  rtc_snap_sync #(.STAGES(SYNC_STAGES)) reqSync_i (
    .clk(slowClk), .rstN(rstN), .d(reqTgl), .q(reqSync)
  );

  // Slow side: edge-detect the toggle. reqSeen doubles as the ack toggle.
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) reqSeen <= 1'b0;
    else       reqSeen <= reqSync;
  end
  assign stb.capture = reqSync ^ reqSeen;

  rtc_snap_sync #(.STAGES(SYNC_STAGES)) ackSync_i (
    .clk(busClk), .rstN(rstN), .d(reqSeen), .q(ackSync)
  );

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) ackSeen <= 1'b0;
    else       ackSeen <= ackSync;
  end
  assign done    = ackSync ^ ackSeen;
  assign pending = reqTgl ^ ackSeen;

  // Ready flag: a completing capture wins over a clear in the same cycle.
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)      validQ <= 1'b0;
    else if (done)  validQ <= 1'b1;
    else if (clrWr) validQ <= 1'b0;
  end

  p_valid_clr_r5: assert property (@(posedge busClk) disable iff (!rstN)
    clrWr && !done |=> !validQ);
  p_valid_keep_r5: assert property (@(posedge busClk) disable iff (!rstN)
    validQ && !clrWr |=> validQ);
  p_merge_r8: assert property (@(posedge busClk) disable iff (!rstN)
    updWr && pending |=> $stable(reqTgl));
  p_busy_set_r9: assert property (@(posedge busClk) disable iff (!rstN)
    updWr && !pending |=> pending);
  p_one_capture_r3: assert property (@(posedge slowClk) disable iff (!rstN)
    stb.capture |=> !stb.capture);
endmodule

// File: rtl/rtc_snap_datapath.sv
module rtc_snap_datapath
  import rtc_snap_pkg::*;
#(
  parameter int          CNT_W    = 48,
  parameter logic [63:0] CNT_INIT = 64'd0
) (
  input  logic         slowClk,
  input  logic         rstN,
  input  slowStrobes_t stb,
  output logic [31:0]  loWord,
  output logic [31:0]  hiWord
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] snap;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) count <= CNT_INIT[CNT_W-1:0];
    else       count <= count + 1'b1;
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN)            snap <= '0;
    else if (stb.capture) snap <= count;
  end

  assign loWord = snap[31:0];
  assign hiWord = {{(32-HI_W){1'b0}}, snap[CNT_W-1:32]};

  p_count_inc_r2: assert property (@(posedge slowClk) disable iff (!rstN)
    1'b1 |=> count == CNT_W'($past(count) + 1'b1));
  p_snap_hold_r7: assert property (@(posedge slowClk) disable iff (!rstN)
    !stb.capture |=> $stable(snap));
endmodule

// File: rtl/rtc_snap_top.sv
module rtc_snap_top
  import rtc_snap_pkg::*;
#(
  parameter int          CNT_W       = 48,
  parameter logic [63:0] CNT_INIT    = 64'd0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        busClk,
  input  logic        slowClk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [1:0]  busAddr,
  input  logic        busWrBit,
  output logic [31:0] busRdData
);
  slowStrobes_t stb;
  logic validQ, pending;
  logic [31:0] loWord, hiWord;

  rtc_snap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrBit(busWrBit),
    .stb(stb), .validQ(validQ), .pending(pending)
  );

  rtc_snap_datapath #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) dp_i (
    .slowClk(slowClk), .rstN(rstN), .stb(stb),
    .loWord(loWord), .hiWord(hiWord)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CMD: busRdData = {30'd0, pending, validQ};
      ADDR_CLR: busRdData = '0;
      ADDR_LO:  busRdData = loWord;
      ADDR_HI:  busRdData = hiWord;
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: tb/rtc_snap_top_tb_top.sv
module rtc_snap_top_tb_top;
  localparam logic [63:0] INIT = 64'h0000_FFFF_FFFF_FA24; // 1500 edges below 2^48
  localparam int MAX_WAIT = 74;

  logic busClk = 1'b0, slowClk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, busWrBit = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [31:0] busRdData;

  int checks = 0, fails = 0;
  longint unsigned slowEdges = 0;
  longint unsigned lastOff = 0;
  bit haveLast = 0;
  int cyc = 0;

  rtc_snap_top #(.CNT_W(48), .CNT_INIT(INIT), .SYNC_STAGES(2)) dut_i (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrBit(busWrBit),
    .busRdData(busRdData)
  );

  always #5 busClk = ~busClk;
  initial begin
    #3;
    forever begin slowClk = 1'b1; #85; slowClk = 1'b0; #85; end
  end
  always @(posedge slowClk) if (rstN) slowEdges++;

  function automatic longint unsigned offsetOf(logic [47:0] v);
    logic [47:0] d;
    d = v - INIT[47:0];
    return longint'(d);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge busClk) begin
    cyc++;
    if (cyc > 180000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 180000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic b);
    @(negedge busClk);
    busWrEn = 1'b1; busAddr = a; busWrBit = b;
    @(negedge busClk);
    busWrEn = 1'b0; busWrBit = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [31:0] d);
    @(negedge busClk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic idleBus(int n);
    for (int i = 0; i < n; i++) @(negedge busClk);
  endtask

  task automatic readSnap(output logic [31:0] lo, output logic [31:0] hi);
    busRead(2'd2, lo);
    busRead(2'd3, hi);
  endtask

  // Clear, request, poll, and check the captured value.
  task automatic doCapture(bit doubleReq);
    logic [31:0] st, lo, hi;
    longint unsigned e0, e1, off;
    int waited;
    busWrite(2'd1, 1'b1);
    e0 = slowEdges;
    busWrite(2'd0, 1'b1);
    if (doubleReq) busWrite(2'd0, 1'b1);
    busRead(2'd0, st);
    check(st[1:0] == 2'b10, "R9 busy after request", st[1:0], 2'b10);
    waited = 0;
    while (!st[0] && waited < MAX_WAIT + 4) begin
      busRead(2'd0, st);
      waited++;
    end
    e1 = slowEdges;
    check(waited <= MAX_WAIT, "R4 ready latency", waited, MAX_WAIT);
    check(st[1:0] == 2'b01, "R9 busy low once ready", st[1:0], 2'b01);
    readSnap(lo, hi);
    check(hi[31:16] == 16'd0, "R6 high word zero-extended", hi, {16'd0, hi[15:0]});
    off = offsetOf({hi[15:0], lo});
    check(off >= e0 && off < e1, "R3 captured value in window", off, e0);
    if (haveLast)
      check(off > lastOff, "R2 count advances across captures", off, lastOff + 1);
    lastOff = off; haveLast = 1;
    if (doubleReq) begin
      busWrite(2'd1, 1'b1);
      idleBus(17 * 8);
      busRead(2'd0, st);
      check(st[1:0] == 2'b00, "R8 merged request gave no second capture", st[1:0], 0);
    end
  endtask

  initial begin
    logic [31:0] st, lo, hi, lo2, hi2;
    void'($urandom(32'd20240611));
    idleBus(3);
    busRead(2'd0, st);
    check(st[1:0] == 2'b00, "R1 flags in reset", st[1:0], 0);
    @(negedge busClk) rstN = 1'b1;
    busRead(2'd0, st);
    check(st[1:0] == 2'b00, "R1 flags after reset", st[1:0], 0);
    readSnap(lo, hi);
    check(lo == 32'd0, "R1 low word after reset", lo, 0);
    check(hi == 32'd0, "R1 high word after reset", hi, 0);

    // R10: command bit clear does nothing.
    busWrite(2'd0, 1'b0);
    idleBus(17 * 6);
    busRead(2'd0, st);
    check(st[1:0] == 2'b00, "R10 zero-bit request ignored", st[1:0], 0);

    doCapture(1'b0);

    // R5: ready persists, zero-bit clear ignored, real clear works.
    idleBus(50);
    busRead(2'd0, st);
    check(st[0] == 1'b1, "R5 ready persists", st[0], 1);
    busWrite(2'd1, 1'b0);
    busRead(2'd0, st);
    check(st[0] == 1'b1, "R5 zero-bit clear ignored", st[0], 1);
    busWrite(2'd1, 1'b1);
    busRead(2'd0, st);
    check(st[0] == 1'b0, "R5 clear drops ready", st[0], 0);

    doCapture(1'b1);

    for (int it = 0; it < 800 && slowEdges < 1800; it++) begin
      int sel;
      sel = int'($urandom_range(0, 7));
      idleBus(int'($urandom_range(0, 30)));
      if (sel == 6) doCapture(1'b1);
      else if (sel == 7) begin
        busWrite(2'd0, 1'b0);
        busWrite(2'd1, 1'b0);
        idleBus(17 * 4);
        busRead(2'd0, st);
        check(st[1] == 1'b0, "R10 zero-bit writes start nothing", st[1], 0);
      end else begin
        doCapture(1'b0);
        if (sel < 2) begin
          readSnap(lo, hi);
          idleBus(int'($urandom_range(40, 400)));
          readSnap(lo2, hi2);
          check({hi2, lo2} == {hi, lo}, "R7 snapshot holds",
                {hi2, lo2}, {hi, lo});
        end
      end
    end
    check(slowEdges >= 1500, "R2 run crossed 48-bit wrap", slowEdges, 1500);
    doCapture(1'b0);
    readSnap(lo, hi);
    check(hi[15:0] == 16'd0, "R6 high word after wrap", hi, 0);

    summary();
    $finish;
  end
endmodule